// File: doc/BRIEF.md
# Prioritized UART Interrupt Identification Unit

This block collects the five interrupt causes of a UART: receiver line status, received data ready, receive data time-out, transmit holding empty and modem status. Each cause arrives as a one-cycle event pulse. The pulse sets a sticky pending flag. A per-cause enable decides whether that flag may raise the interrupt line and be reported.

A read-only 8-bit status byte always shows the most urgent enabled pending cause. Its low bit is low whenever something is pending. The two FIFO configuration inputs are mirrored in the upper bits. A read strobe acknowledges only the cause shown in that cycle, so software that reads repeatedly walks down the pending causes in priority order. The bus decoding, FIFOs, baud generator and the line and modem status registers sit outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, every pending flag is clear, `irq` is 0 and `rd_data[3:0]` reads 0001.
- R2: A one-cycle pulse on `src_evt[i]` sets pending flag i at the next clock edge. The flag stays set until a read acknowledges it. Bit order: 0 line status, 1 data ready, 2 data time-out, 3 transmit holding empty, 4 modem status.
- R3: Priority, most urgent first: line status, then data ready, then data time-out, then transmit holding empty, then modem status. Data ready and data time-out share one level, and within it data ready wins.
- R4: `rd_data[3:0]` identifies the reported cause: line status 0110, data ready 0100, data time-out 1100, transmit holding empty 0010, modem status 0000.
- R5: `rd_data[0]` is active-low. It is 0 while any enabled cause is pending and 1 when none is.
- R6: `rd_data[7]` and `rd_data[6]` both equal `fifo_en`. `rd_data[5]` equals `fifo_deep` (1 means 64-byte mode). `rd_data[4]` is always 0.
- R7: A cycle with `rd_stb` high returns the current byte. At the next edge it clears only the cause that byte reported, and the next lower pending cause becomes visible. A read with nothing reported clears nothing.
- R8: If an event for the reported cause arrives in the same cycle as its read, that cause stays pending.
- R9: A cause whose `src_en` bit is 0 is never reported and does not drive `irq`. Its flag is still latched and appears once the cause is enabled.
- R10: `irq` is 1 exactly when some cause is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | 5 | One-cycle event pulses per cause |
| src_en | input | 5 | Per-cause enable |
| fifo_en | input | 1 | FIFOs enabled indication |
| fifo_deep | input | 1 | 64-byte FIFO mode indication |
| rd_stb | input | 1 | Status byte read strobe |
| rd_data | output | 8 | Status byte |
| irq | output | 1 | Active-high interrupt request |

## Verification
Two functions can fall in the same clock cycle: a read acknowledging the reported cause, and a fresh event for that same cause. The bench first makes data ready pending. It then drives the read strobe and a new data-ready pulse in the same cycle. It judges the result at the ports: the byte returned in that cycle must report data ready, and the byte in the following cycle must still report data ready with `irq` high. A further read must then clear it. A checker also confirms that an uncontested read removes exactly one pending flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int CODE_W  = 3;

  typedef enum int {
    SRC_LINE  = 0,
    SRC_RXRDY = 1,
    SRC_RXTO  = 2,
    SRC_THRE  = 3,
    SRC_MODEM = 4
  } src_idx_e;

  // identification bits [3:1] of the status byte per source index
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    logic [CODE_W-1:0] c;
    case (idx)
      SRC_LINE:  c = 3'b011;
      SRC_RXRDY: c = 3'b010;
      SRC_RXTO:  c = 3'b110;
      SRC_THRE:  c = 3'b001;
      default:   c = 3'b000;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/uart_irq_rst_sync.sv
module uart_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic         upd_en;

  // set has priority over clear, per flag
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_comb begin
      pend_d[g] = evt[g] | (pend_q[g] & ~clr[g]);
    end
  end

  always_comb begin
    upd_en = (|evt) | (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]      pend,
  input  logic [N-1:0]      en,
  output logic [N-1:0]      grant,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  logic [N-1:0] live;

  always_comb begin
    live = pend & en;
  end

  // lowest index is most urgent
  always_comb begin
    grant = '0;
    valid = 1'b0;
    code  = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid && live[i]) begin
        grant[i] = 1'b1;
        valid    = 1'b1;
        code     = src_code(i);
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               fifo_en,
  input  logic               fifo_deep,
  input  logic               rd_stb,
  output logic [7:0]         rd_data,
  output logic               irq
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] clr;
  logic               valid;
  logic [CODE_W-1:0]  code;

  uart_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_irq_pend #(.N(NUM_SRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .evt   (src_evt),
    .clr   (clr),
    .pend  (pend_q)
  );

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .pend  (pend_q),
    .en    (src_en),
    .grant (grant),
    .valid (valid),
    .code  (code)
  );

  always_comb begin
    clr = rd_stb ? grant : '0;
  end

  always_comb begin
    rd_data = {fifo_en, fifo_en, fifo_deep, 1'b0, code, ~valid};
    irq     = |(pend_q & src_en);
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic [NUM_SRC-1:0] src_en,
  input logic               rd_stb,
  input logic [7:0]         rd_data,
  input logic               irq,
  input logic [NUM_SRC-1:0] pend_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[g] |=> pend_q[g]);
  end

  // R2
  no_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R7
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_data[0] && src_evt == '0)
      |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  // R5
  irq_vs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq != rd_data[0]);

  // R4
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> (rd_data[3:1] == 3'b000));

  // R6
  cfg_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] == 1'b0) && (rd_data[7] == rd_data[6]));

  // R9
  masked_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en[SRC_LINE] |-> (rd_data[3:0] != 4'b0110));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .src_evt (src_evt),
  .src_en  (src_en),
  .rd_stb  (rd_stb),
  .rd_data (rd_data),
  .irq     (irq),
  .pend_q  (pend_q)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic       clk;
  logic       rst_n;
  logic [4:0] src_evt;
  logic [4:0] src_en;
  logic       fifo_en;
  logic       fifo_deep;
  logic       rd_stb;
  logic [7:0] rd_data;
  logic       irq;

  int checks;
  int failures;
  bit done;

  localparam logic [3:0] C_NONE  = 4'b0001;
  localparam logic [3:0] C_LINE  = 4'b0110;
  localparam logic [3:0] C_RXRDY = 4'b0100;
  localparam logic [3:0] C_RXTO  = 4'b1100;
  localparam logic [3:0] C_THRE  = 4'b0010;
  localparam logic [3:0] C_MODEM = 4'b0000;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en),
    .fifo_en(fifo_en), .fifo_deep(fifo_deep), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_byte(input logic [3:0] nib);
    return {fifo_en, fifo_en, fifo_deep, 1'b0, nib};
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk); src_evt = m;
    @(negedge clk); src_evt = '0;
    #1;
  endtask

  task automatic do_read(input logic [3:0] nib, input string req);
    @(negedge clk); rd_stb = 1'b1;
    #1 chk8(req, rd_data, exp_byte(nib));
    @(negedge clk); rd_stb = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    // R1 R5: idle byte and quiet interrupt
    chk8("R1 reset byte", rd_data, 8'h01);
    chk1("R1 reset irq", irq, 1'b0);
  endtask

  task automatic t_codes;
    logic [3:0] nibs [5];
    nibs = '{C_LINE, C_RXRDY, C_RXTO, C_THRE, C_MODEM};
    src_en = 5'b11111;
    for (int i = 0; i < 5; i++) begin
      pulse(5'(1 << i));
      // R4 R2 R10
      chk8("R4 code", rd_data, exp_byte(nibs[i]));
      chk1("R10 irq high", irq, 1'b1);
      do_read(nibs[i], "R4 read code");
      chk8("R7 cleared", rd_data, exp_byte(C_NONE));
      chk1("R5 idle irq", irq, 1'b0);
    end
  endtask

  task automatic t_priority;
    pulse(5'b11111);
    // R3 R7: each read exposes the next lower cause
    do_read(C_LINE,  "R3 first");
    do_read(C_RXRDY, "R3 second");
    do_read(C_RXTO,  "R3 third");
    do_read(C_THRE,  "R7 fourth");
    do_read(C_MODEM, "R7 fifth");
    chk8("R7 all cleared", rd_data, exp_byte(C_NONE));
    // R7: read with nothing reported clears nothing and stays idle
    do_read(C_NONE, "R7 empty read");
  endtask

  task automatic t_level2;
    pulse(5'b00100);
    pulse(5'b00010);
    chk8("R3 data ready over timeout", rd_data, exp_byte(C_RXRDY));
    do_read(C_RXRDY, "R3 lvl2 a");
    do_read(C_RXTO,  "R3 lvl2 b");
  endtask

  task automatic t_latched;
    pulse(5'b01000);
    repeat (10) @(negedge clk);
    #1 chk8("R2 flag held", rd_data, exp_byte(C_THRE));
    do_read(C_THRE, "R2 held read");
  endtask

  task automatic t_disabled;
    src_en = 5'b01111;
    pulse(5'b10000);
    chk8("R9 masked not reported", rd_data, exp_byte(C_NONE));
    chk1("R9 masked no irq", irq, 1'b0);
    // a read while masked must not consume the latched flag
    do_read(C_NONE, "R9 masked read");
    @(negedge clk); src_en = 5'b11111;
    #1 chk8("R9 revealed", rd_data, exp_byte(C_MODEM));
    chk1("R10 irq after enable", irq, 1'b1);
    do_read(C_MODEM, "R9 revealed read");
    // R10: masked higher cause, enabled lower one
    src_en = 5'b11110;
    pulse(5'b01001);
    chk8("R9 line masked", rd_data, exp_byte(C_THRE));
    do_read(C_THRE, "R9 lower read");
    chk1("R10 masked only pending", irq, 1'b0);
    src_en = 5'b11111;
    #1 do_read(C_LINE, "R9 line after enable");
  endtask

  task automatic t_collide;
    pulse(5'b00010);
    @(negedge clk); rd_stb = 1'b1; src_evt = 5'b00010;
    #1 chk8("R8 read value", rd_data, exp_byte(C_RXRDY));
    @(negedge clk); rd_stb = 1'b0; src_evt = '0;
    #1 chk8("R8 still pending", rd_data, exp_byte(C_RXRDY));
    chk1("R8 irq kept", irq, 1'b1);
    do_read(C_RXRDY, "R8 final read");
    chk1("R8 cleared", irq, 1'b0);
  endtask

  task automatic t_cfg;
    fifo_en = 1'b1; fifo_deep = 1'b1;
    #1 chk8("R6 fifo+deep", rd_data, 8'hE1);
    fifo_deep = 1'b0;
    #1 chk8("R6 fifo only", rd_data, 8'hC1);
    pulse(5'b00001);
    chk8("R6 with code", rd_data, 8'hC6);
    do_read(C_LINE, "R6 read");
    fifo_en = 1'b0;
    #1 chk8("R6 off", rd_data, 8'h01);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; src_evt = '0; src_en = '0;
    fifo_en = 1'b0; fifo_deep = 1'b0; rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_codes();
    t_priority();
    t_level2();
    t_latched();
    t_disabled();
    t_collide();
    t_cfg();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule